// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides whether a small system runs at full speed, sleeps with only the processor clock stopped (Halt), or sleeps with every clock stopped (Standby). Software moves it out of Run with ordinary register accesses on a simple single-cycle bus port. A read of either of two trigger addresses starts a guarded entry, and only takes effect when a sleep-enable bit in the configuration register is set. Any write to the clock-setting register starts an unguarded Standby entry, which lasts only while the new clock setting settles.

A Standby entered through a clock-register write ends by itself. With the PLL in use it ends when the PLL reports lock. With the PLL bypassed it ends after a minimum off-time, counted with a 16.384 kHz tick that the block derives by halving a 32.768 kHz tick strobe. Any interrupt that is both requested and enabled brings the block back to Run from Halt or from any Standby. When external memory refresh is enabled, the block asks the SDRAM controller to enter self-refresh before it stops the clocks, and waits for the acknowledge. On exit it restores the clocks before it withdraws that request.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode status reads 2'b00 (Run), both clock enables are 1, the self-refresh request is 0 and the configuration register reads 0.
- R2: A bus read of address 1 moves Run to Standby (status 2'b10, both clock enables 0) when configuration bit 0 is 1. When that bit is 0, the read leaves the mode at Run.
- R3: A bus read of address 2 moves Run to Halt when configuration bit 0 is 1. In Halt the status is 2'b01, the CPU clock enable is 0 and the system clock enable is 1. When configuration bit 0 is 0, the read leaves the mode at Run.
- R4: A bus write to address 3 moves Run to Standby whatever configuration bit 0 holds. The written value reads back at address 3, and the configuration register reads back at address 0.
- R5: With the bypass input at 0, a Standby entered by a clock-register write returns to Run one clock after the PLL lock input is seen high. It does not return to Run while lock stays low.
- R6: With the bypass input at 1, a Standby entered by a clock-register write ends after two periods of the internal half-rate tick. The block is still in Standby after two 32.768 kHz tick pulses and is back in Run after four.
- R7: When the bitwise AND of the interrupt request and enable vectors is nonzero, the block returns from Halt or Standby to Run. A request whose enable bit is 0 leaves the mode unchanged.
- R8: A Standby entered by a read of address 1 ignores both PLL lock and the off-time tick, and ends only on an enabled interrupt.
- R9: With the refresh-enable input at 1, a Standby entry first raises the self-refresh request with both clocks still on. The clocks stop only after the acknowledge is seen. With refresh-enable at 0, the request stays 0.
- R10: On leaving a Standby that used self-refresh, both clock enables return to 1 one cycle before the self-refresh request falls. The status reads 2'b00 in the cycle the request falls.
- R11: In Run both clock enables are 1, and the mode status never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe for one cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | 0 config, 1 Standby trigger, 2 Halt trigger, 3 clock setting |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data (config or clock setting, else 0) |
| irqReq | input | IRQ_N | Interrupt request lines |
| irqEn | input | IRQ_N | Interrupt enable mask |
| pllLocked | input | 1 | PLL lock flag |
| pllBypass | input | 1 | 1 = PLL bypassed |
| tick32k | input | 1 | One-cycle strobe at 32.768 kHz |
| refreshEn | input | 1 | SDRAM refresh enabled |
| srAck | input | 1 | Self-refresh acknowledge |
| cpuClkEn | output | 1 | Processor clock enable |
| sysClkEn | output | 1 | System clock enable |
| srReq | output | 1 | Self-refresh request |
| modeStat | output | 2 | 00 Run, 01 Halt, 10 Standby |

## Verification
The entry path is tried with every pairing of trigger kind (Standby read, Halt read, clock write) and sleep-enable value. This separates the guarded reads from the unguarded write, and Halt from Standby by the pattern of clock enables. Exits are tried with a masked interrupt, an enabled one, PLL lock, and counted tick pulses. Lock and ticks are also applied to a read-entered Standby, which shows that the exit rule depends on how Standby was entered. A run with refresh enabled and a delayed acknowledge fixes the order of request, gating, clock restore and request release.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_HALT, ST_SRWAIT, ST_STBY, ST_WAKE
  } lpmState_t;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_HALT = 2'b01;
  localparam logic [1:0] MODE_STBY = 2'b10;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STBY = 2'd1;
  localparam logic [1:0] ADDR_HALT = 2'd2;
  localparam logic [1:0] ADDR_CLK  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic clrOff;
    logic cntOn;
  } dpCtl_t;

  // decoded events from datapath to control
  typedef struct packed {
    logic sleepEn;
    logic stbyRd;
    logic haltRd;
    logic clkWr;
    logic offDone;
  } dpStat_t;
endpackage

// File: rtl/lpm_ctrl_dp.sv
module lpm_ctrl_dp
  import lpm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OFF_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tick32k,
  input  dpCtl_t            ctl,
  output dpStat_t           stat
);
  localparam int CNT_W = $clog2(OFF_TICKS + 1);

  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] clkReg;
  logic              divPhase;
  logic [CNT_W-1:0]  offCnt;
  logic              tick16;
  logic              offDone;
  logic              wrAcc;
  logic              rdAcc;

  assign wrAcc  = busSel && busWr;
  assign rdAcc  = busSel && !busWr;
  assign tick16 = tick32k && divPhase;
  assign offDone = (offCnt >= CNT_W'(OFF_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      clkReg <= '0;
    end else if (wrAcc) begin
      if (busAddr == ADDR_CFG) cfgReg <= busWdata;
      if (busAddr == ADDR_CLK) clkReg <= busWdata;
    end
  end

  // halve the 32.768 kHz strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divPhase <= 1'b0;
    else if (tick32k) divPhase <= !divPhase;
  end

  // minimum off-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               offCnt <= '0;
    else if (ctl.clrOff)                     offCnt <= '0;
    else if (ctl.cntOn && tick16 && !offDone) offCnt <= offCnt + 1'b1;
  end

  always_comb begin
    case (busAddr)
      ADDR_CFG: busRdata = cfgReg;
      ADDR_CLK: busRdata = clkReg;
      default:  busRdata = '0;
    endcase
  end

  assign stat.sleepEn = cfgReg[0];
  assign stat.stbyRd  = rdAcc && (busAddr == ADDR_STBY);
  assign stat.haltRd  = rdAcc && (busAddr == ADDR_HALT);
  assign stat.clkWr   = wrAcc && (busAddr == ADDR_CLK);
  assign stat.offDone = offDone;
endmodule

// File: rtl/lpm_ctrl_fsm.sv
module lpm_ctrl_fsm
  import lpm_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStat_t          stat,
  input  logic [IRQ_N-1:0] irqReq,
  input  logic [IRQ_N-1:0] irqEn,
  input  logic             pllLocked,
  input  logic             pllBypass,
  input  logic             refreshEn,
  input  logic             srAck,
  output dpCtl_t           ctl,
  output logic             cpuClkEn,
  output logic             sysClkEn,
  output logic             srReq,
  output logic [1:0]       modeStat
);
  lpmState_t state, nextState;
  logic fromClk, fromClkNext;
  logic srUsed, srUsedNext;
  logic irqAny, goSleep, wakeUp;

  assign irqAny  = |(irqReq & irqEn);
  assign goSleep = (stat.stbyRd && stat.sleepEn) || stat.clkWr;
  assign wakeUp  = irqAny ||
                   (fromClk && (pllBypass ? stat.offDone : pllLocked));

  always_comb begin
    nextState   = state;
    fromClkNext = fromClk;
    srUsedNext  = srUsed;
    unique case (state)
      ST_RUN: begin
        if (goSleep) begin
          nextState   = refreshEn ? ST_SRWAIT : ST_STBY;
          fromClkNext = stat.clkWr;
          srUsedNext  = refreshEn;
        end else if (stat.haltRd && stat.sleepEn) begin
          nextState = ST_HALT;
        end
      end
      ST_HALT:   if (irqAny) nextState = ST_RUN;
      ST_SRWAIT: if (srAck)  nextState = ST_STBY;
      ST_STBY:   if (wakeUp) nextState = srUsed ? ST_WAKE : ST_RUN;
      ST_WAKE:   nextState = ST_RUN;
      default:   nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      fromClk <= 1'b0;
      srUsed  <= 1'b0;
    end else begin
      state   <= nextState;
      fromClk <= fromClkNext;
      srUsed  <= srUsedNext;
    end
  end

  assign ctl.clrOff = (nextState == ST_STBY) && (state != ST_STBY);
  assign ctl.cntOn  = (state == ST_STBY);

  always_comb begin
    cpuClkEn = 1'b1;
    sysClkEn = 1'b1;
    modeStat = MODE_RUN;
    case (state)
      ST_HALT: begin
        cpuClkEn = 1'b0;
        modeStat = MODE_HALT;
      end
      ST_STBY: begin
        cpuClkEn = 1'b0;
        sysClkEn = 1'b0;
        modeStat = MODE_STBY;
      end
      ST_SRWAIT, ST_WAKE: modeStat = MODE_STBY;
      default: ;
    endcase
  end

  assign srReq = srUsed &&
                 (state == ST_SRWAIT || state == ST_STBY || state == ST_WAKE);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IRQ_N     = 8,
  parameter int OFF_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [IRQ_N-1:0]  irqReq,
  input  logic [IRQ_N-1:0]  irqEn,
  input  logic              pllLocked,
  input  logic              pllBypass,
  input  logic              tick32k,
  input  logic              refreshEn,
  input  logic              srAck,
  output logic              cpuClkEn,
  output logic              sysClkEn,
  output logic              srReq,
  output logic [1:0]        modeStat
);
  dpCtl_t  ctl;
  dpStat_t stat;

  lpm_ctrl_dp #(.DATA_W(DATA_W), .OFF_TICKS(OFF_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tick32k(tick32k), .ctl(ctl), .stat(stat)
  );

  lpm_ctrl_fsm #(.IRQ_N(IRQ_N)) fsm_i (
    .clk(clk), .rstN(rstN), .stat(stat), .irqReq(irqReq), .irqEn(irqEn),
    .pllLocked(pllLocked), .pllBypass(pllBypass), .refreshEn(refreshEn),
    .srAck(srAck), .ctl(ctl), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn),
    .srReq(srReq), .modeStat(modeStat)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int IRQ_N = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [IRQ_N-1:0] irqReq,
  input logic [IRQ_N-1:0] irqEn,
  input logic             srAck,
  input logic             cpuClkEn,
  input logic             sysClkEn,
  input logic             srReq,
  input logic [1:0]       modeStat
);
  // R11
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeStat != 2'b11);

  // R11
  run_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStat == 2'b00) |-> (cpuClkEn && sysClkEn));

  // R3
  halt_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStat == 2'b01) |-> (!cpuClkEn && sysClkEn));

  // R7
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeStat == 2'b01 && |(irqReq & irqEn)) |=> (modeStat == 2'b00));

  // R9
  gate_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sysClkEn) && srReq) |-> $past(srAck));

  // R10
  clocks_before_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srReq) |-> (sysClkEn && $past(sysClkEn) && $past(cpuClkEn)));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.IRQ_N(IRQ_N)) chk_i (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEn(irqEn), .srAck(srAck),
  .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn), .srReq(srReq),
  .modeStat(modeStat)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int IRQ_N  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [1:0]        busAddr = 2'd0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [IRQ_N-1:0]  irqReq = '0;
  logic [IRQ_N-1:0]  irqEn = '0;
  logic              pllLocked = 1'b0;
  logic              pllBypass = 1'b0;
  logic              tick32k = 1'b0;
  logic              refreshEn = 1'b0;
  logic              srAck = 1'b0;
  logic              cpuClkEn, sysClkEn, srReq;
  logic [1:0]        modeStat;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  lpm_ctrl #(.DATA_W(DATA_W), .IRQ_N(IRQ_N), .OFF_TICKS(2)) dut_i (.*);

  // {sleepEn, op(0 stby rd,1 halt rd,2 clk wr), expMode, expCpu, expSys}
  localparam logic [6:0] VEC [6] = '{
    {1'b1, 2'd0, 2'b10, 1'b0, 1'b0},
    {1'b0, 2'd0, 2'b00, 1'b1, 1'b1},
    {1'b1, 2'd1, 2'b01, 1'b0, 1'b1},
    {1'b0, 2'd1, 2'b00, 1'b1, 1'b1},
    {1'b0, 2'd2, 2'b10, 1'b0, 1'b0},
    {1'b1, 2'd2, 2'b10, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic irqPulse(input logic [IRQ_N-1:0] req, input logic [IRQ_N-1:0] en);
    @(negedge clk);
    irqReq = req; irqEn = en;
    @(negedge clk);
    irqReq = '0; irqEn = '0;
  endtask

  task automatic tickPulse();
    @(negedge clk);
    tick32k = 1'b1;
    @(negedge clk);
    tick32k = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", {30'd0, modeStat}, 32'h0);
    check("R1 cpuClkEn", {31'd0, cpuClkEn}, 32'h1);
    check("R1 sysClkEn", {31'd0, sysClkEn}, 32'h1);
    check("R1 srReq", {31'd0, srReq}, 32'h0);
    busRead(2'd0, rd);
    check("R1 cfg", {24'd0, rd}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R11 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [6:0] v;
      v = VEC[i];
      busWrite(2'd0, {7'd0, v[6]});
      if (v[5:4] == 2'd2) busWrite(2'd3, 8'h30 + 8'(i));
      else busRead(v[5:4] == 2'd0 ? 2'd1 : 2'd2, rd);
      check($sformatf("R2/R3/R4 vec%0d mode", i), {30'd0, modeStat}, {30'd0, v[3:2]});
      check($sformatf("R11 vec%0d cpu", i), {31'd0, cpuClkEn}, {31'd0, v[1]});
      check($sformatf("R11 vec%0d sys", i), {31'd0, sysClkEn}, {31'd0, v[0]});
      irqPulse(8'h04, 8'h04);
      check($sformatf("R7 vec%0d wake", i), {30'd0, modeStat}, 32'h0);
    end

    // R4 readback
    busRead(2'd3, rd);
    check("R4 clk readback", {24'd0, rd}, 32'h35);
    busRead(2'd0, rd);
    check("R4 cfg readback", {24'd0, rd}, 32'h1);

    // R7 masked interrupt ignored in Halt
    busRead(2'd2, rd);
    irqPulse(8'hFF, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 masked halt", {30'd0, modeStat}, 32'h1);
    irqPulse(8'h81, 8'h80);
    check("R7 enabled halt", {30'd0, modeStat}, 32'h0);

    // R5 PLL lock exit
    pllBypass = 1'b0; pllLocked = 1'b0;
    busWrite(2'd3, 8'h11);
    repeat (4) @(negedge clk);
    check("R5 wait lock", {30'd0, modeStat}, 32'h2);
    pllLocked = 1'b1;
    @(negedge clk);
    check("R5 lock exit", {30'd0, modeStat}, 32'h0);

    // R8 read-entered standby ignores lock and ticks
    busRead(2'd1, rd);
    repeat (3) @(negedge clk);
    check("R8 lock ignored", {30'd0, modeStat}, 32'h2);
    pllBypass = 1'b1;
    repeat (5) tickPulse();
    check("R8 ticks ignored", {30'd0, modeStat}, 32'h2);
    irqPulse(8'h01, 8'h01);
    check("R8 irq exit", {30'd0, modeStat}, 32'h0);
    pllLocked = 1'b0;

    // R6 bypass minimum off-time
    busWrite(2'd3, 8'h22);
    repeat (3) @(negedge clk);
    tickPulse();
    tickPulse();
    check("R6 still off", {30'd0, modeStat}, 32'h2);
    tickPulse();
    tickPulse();
    check("R6 back to run", {30'd0, modeStat}, 32'h0);

    // R9 R10 self-refresh handshake
    refreshEn = 1'b1; srAck = 1'b0;
    busRead(2'd1, rd);
    check("R9 srReq raised", {31'd0, srReq}, 32'h1);
    check("R9 clocks on before ack", {30'd0, cpuClkEn, sysClkEn}, 32'h3);
    check("R9 mode", {30'd0, modeStat}, 32'h2);
    repeat (3) @(negedge clk);
    check("R9 wait ack", {31'd0, sysClkEn}, 32'h1);
    srAck = 1'b1;
    @(negedge clk);
    check("R9 gated after ack", {30'd0, cpuClkEn, sysClkEn}, 32'h0);
    check("R9 srReq held", {31'd0, srReq}, 32'h1);
    irqPulse(8'h02, 8'h02);
    check("R10 clocks first", {30'd0, cpuClkEn, sysClkEn}, 32'h3);
    check("R10 srReq still up", {31'd0, srReq}, 32'h1);
    @(negedge clk);
    check("R10 srReq dropped", {31'd0, srReq}, 32'h0);
    check("R10 run", {30'd0, modeStat}, 32'h0);
    srAck = 1'b0;

    // R9 no request when refresh disabled
    refreshEn = 1'b0;
    busRead(2'd1, rd);
    check("R9 no srReq", {31'd0, srReq}, 32'h0);
    check("R9 gated direct", {30'd0, cpuClkEn, sysClkEn}, 32'h0);
    irqPulse(8'h10, 8'h10);
    check("R7 standby wake", {30'd0, modeStat}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule